// File: doc/BRIEF.md
# UART Receive Buffer with Status Flags

This block holds characters that a UART's bit-level deserializer has finished assembling, until the bus reads them. Each stored entry is twelve bits wide. The low eight bits are the character. The upper four bits are the line error indications captured with it. A line-break event is stored in the same buffer as a pseudo-character: the data is zero and only the break error bit is set. The oldest entry is always visible on the read-data port. A read strobe consumes that entry and latches its error bits into a receive-status register. Software can later clear that register.

A buffer-enable input chooses between two modes. In buffered mode the block keeps up to `DEPTH` characters, 16 by default, in a circular store. In holding mode it keeps exactly one character. A change of this input in either direction empties the buffer. The block drives the following:
- registered empty and full flags, for a flag register;
- one-cycle pulses asking an interrupt controller to set or clear the receive interrupt, tied to the fill level;
- a ready signal that tells the deserializer whether a character offered now will be kept.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `status_o`=0, both interrupt pulses are 0, the fill level is 0 and `rd_data_o` reads 0x000. The buffer mode after reset is holding mode.
- R2: In buffered mode, entries come out in arrival order. `rd_data_o` shows the oldest entry. Bits 7:0 carry the character. Bit 8 is framing, bit 9 parity, bit 10 break and bit 11 overrun. A cycle with `rd_i`=1 and a non-empty buffer advances to the next entry.
- R3: `brk_i`=1 stores the entry 0x400. When `push_i` is also 1 in that cycle, the break wins and the character is dropped.
- R4: After each clock edge, `empty_o` is 1 exactly when the fill level is 0. `full_o` is 1 exactly when the fill level equals the active depth (`DEPTH` or 1). A read therefore clears full, and a kept push clears empty.
- R5: `ready_o` is 1 only when both of these hold: `fifo_en_i` equals the mode currently in force, and the fill level is below the active depth. A push or break offered while `ready_o`=0 is discarded and changes nothing.
- R6: A cycle in which `fifo_en_i` differs from the mode in force does three things. It adopts the new mode, it sets both the fill level and the read position to 0, and it ignores pushes and pops. Afterwards `empty_o`=1, `full_o`=0, and `rd_data_o` shows slot 0.
- R7: `rx_irq_set_o` pulses in the cycle after a kept push brings the fill level to `TRIG` (default 1). `rx_irq_clr_o` pulses in the cycle after a read leaves the fill level at `TRIG`-1, and this includes a read of an empty buffer. No pulse follows a mode-change cycle.
- R8: A read while the buffer is empty still presents the entry at the read position. It does not move the read position and does not change the fill level.
- R9: A cycle with `rd_i`=1 loads `status_o` with bits 11:8 of the entry shown on `rd_data_o`. A cycle with `status_clr_i`=1 and `rd_i`=0 loads 0.
- R10: A kept push and a pop in the same cycle leave the fill level unchanged. The new entry is stored, and the read position advances.
- R11: Each write goes to slot (read position + fill level) mod `DEPTH`. Data stays ordered correctly across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects buffered mode, 0 selects holding mode |
| push_i | input | 1 | Deserializer offers a character |
| push_data_i | input | 8 | Character bits |
| push_err_i | input | 4 | Error bits: framing, parity, break, overrun (bits 0..3) |
| brk_i | input | 1 | Break event; stores the pseudo-character 0x400 |
| ready_o | output | 1 | An offer made in this cycle will be kept |
| rd_i | input | 1 | Bus read of the data register |
| rd_data_o | output | 12 | Entry at the read position |
| status_clr_i | input | 1 | Bus write that clears the receive-status register |
| status_o | output | 4 | Receive-status register |
| empty_o | output | 1 | Buffer empty flag |
| full_o | output | 1 | Buffer full flag |
| rx_irq_set_o | output | 1 | One-cycle request to raise the receive interrupt |
| rx_irq_clr_o | output | 1 | One-cycle request to lower the receive interrupt |

## Verification
The bench targets these corner cases, and each has a visible failure mode:
- **Full buffer.** An offer into a full buffer must be refused. A design that accepts it would overwrite the oldest entry, and the model would see a corrupted head.
- **Holding mode.** It must refuse a second character. If it does not, `full_o` never rises.
- **Read on empty.** It must not move the read position. If it does, the stale entry shown on `rd_data_o` changes, and the fill level later wraps so that `empty_o` drops with nothing stored.
- **Mode change.** A design that misses the reset on a mode change keeps stale entries visible after the switch.
- **Push and pop together.** If the design double-counts, the full and empty flags drift.
- **Break arriving with a character.** If the break does not win, the stored entry is wrong.
- **Interrupt pulses.** An off-by-one in the set or clear pulse shows up as a pulse in the wrong cycle, or a missing pulse on an empty read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned ERR_W   = 4;
  localparam int unsigned ENTRY_W = CHAR_W + ERR_W;
  // error bit positions inside the error field (entry bit = CHAR_W + index)
  localparam int unsigned ERR_FRAME = 0;
  localparam int unsigned ERR_PAR   = 1;
  localparam int unsigned ERR_BRK   = 2;
  localparam int unsigned ERR_OVR   = 3;

  typedef logic [ENTRY_W-1:0] rx_entry_t;

  function automatic rx_entry_t break_entry();
    rx_entry_t e;
    e = '0;
    e[CHAR_W + ERR_BRK] = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             push_i,
  input  logic             brk_i,
  input  logic             rd_i,
  output logic             ready_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             mode_q_o,
  output logic             toggle_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, depth_act;
  logic             mode_q, toggle, do_push, do_pop;

  assign toggle    = fifo_en_i ^ mode_q;
  assign depth_act = fifo_en_i ? DEPTH_C : ONE_C;
  assign ready_o   = !toggle && (cnt_q < depth_act);
  assign do_push   = (push_i || brk_i) && ready_o;
  assign do_pop    = rd_i && (cnt_q != '0) && !toggle;

  always_comb begin
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (toggle) begin
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_pop) rptr_d = rptr_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + ONE_C;
        2'b01:   cnt_d = cnt_q - ONE_C;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      mode_q <= fifo_en_i;
    end
  end

  // wraps modulo DEPTH (power of two); count never exceeds DEPTH-1 when a push is kept
  assign wr_ptr_o = rptr_q + cnt_q[PTR_W-1:0];
  assign wr_en_o  = do_push;
  assign rd_ptr_o = rptr_q;
  assign cnt_q_o  = cnt_q;
  assign cnt_d_o  = cnt_d;
  assign mode_q_o = mode_q;
  assign toggle_o = toggle;
endmodule

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  rx_entry_t        wr_data_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output rx_entry_t        rd_data_o
);
  rx_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[i] <= '0;
      else if (wr_en_i && wr_ptr_i == PTR_W'(i))    slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/uart_rx_fifo_flags.sv
module uart_rx_fifo_flags
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic             push_kept_i,
  input  logic             rd_i,
  input  logic             toggle_i,
  input  logic [ERR_W-1:0] head_err_i,
  input  logic             status_clr_i,
  output logic             empty_o,
  output logic             full_o,
  output logic             irq_set_o,
  output logic             irq_clr_o,
  output logic [ERR_W-1:0] status_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(TRIG);
  localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG - 1);

  logic [CNT_W-1:0] depth_d;
  assign depth_d = fifo_en_i ? DEPTH_C : CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o   <= 1'b1;
      full_o    <= 1'b0;
      irq_set_o <= 1'b0;
      irq_clr_o <= 1'b0;
      status_o  <= '0;
    end else begin
      empty_o   <= (cnt_d_i == '0);
      full_o    <= (cnt_d_i == depth_d);
      irq_set_o <= push_kept_i && (cnt_d_i == TRIG_C);
      irq_clr_o <= rd_i && !toggle_i && (cnt_d_i == TRIG_M1);
      if (rd_i)              status_o <= head_err_i;
      else if (status_clr_i) status_o <= '0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               push_i,
  input  logic [CHAR_W-1:0]  push_data_i,
  input  logic [ERR_W-1:0]   push_err_i,
  input  logic               brk_i,
  output logic               ready_o,
  input  logic               rd_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  input  logic               status_clr_i,
  output logic [ERR_W-1:0]   status_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               rx_irq_set_o,
  output logic               rx_irq_clr_o
);
  logic             wr_en, mode_q, toggle;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  rx_entry_t        wr_data, head;

  // break wins over a character offered in the same cycle
  assign wr_data = brk_i ? break_entry() : {push_err_i, push_data_i};

  uart_rx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i, .rst_ni, .fifo_en_i, .push_i, .brk_i, .rd_i,
    .ready_o,
    .wr_en_o  (wr_en),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .cnt_q_o  (cnt_q),
    .cnt_d_o  (cnt_d),
    .mode_q_o (mode_q),
    .toggle_o (toggle)
  );

  uart_rx_fifo_store #(.DEPTH(DEPTH)) store_i (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_data),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (head)
  );

  uart_rx_fifo_flags #(.DEPTH(DEPTH), .TRIG(TRIG)) flags_i (
    .clk_i, .rst_ni, .fifo_en_i,
    .cnt_d_i      (cnt_d),
    .push_kept_i  (wr_en),
    .rd_i,
    .toggle_i     (toggle),
    .head_err_i   (head[ENTRY_W-1:CHAR_W]),
    .status_clr_i,
    .empty_o, .full_o,
    .irq_set_o    (rx_irq_set_o),
    .irq_clr_o    (rx_irq_clr_o),
    .status_o
  );

  assign rd_data_o = head;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             rd_i,
  input logic             status_clr_i,
  input logic             ready_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             rx_irq_set_o,
  input logic             rx_irq_clr_o,
  input logic [3:0]       status_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             mode_q
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R4
  AST_NO_READY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && fifo_en_i == mode_q) |-> !ready_o); // R5
  AST_HOLD_DEPTH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> cnt_q <= CNT_W'(1)); // R5
  AST_MODE_CHANGE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i != mode_q) |=> (empty_o && !full_o && cnt_q == '0)); // R6
  AST_SET_AT_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_set_o |-> cnt_q == CNT_W'(TRIG)); // R7
  AST_CLR_BELOW_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_clr_o |-> cnt_q == CNT_W'(TRIG - 1)); // R7
  AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_irq_set_o && rx_irq_clr_o)); // R7
  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_clr_i && !rd_i) |=> status_o == '0); // R9
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .TRIG(TRIG)) chk_i (
  .clk_i, .rst_ni, .fifo_en_i, .rd_i, .status_clr_i, .ready_o,
  .empty_o, .full_o, .rx_irq_set_o, .rx_irq_clr_o, .status_o,
  .cnt_q, .mode_q
);

// File: tb/uart_rx_fifo_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb_top;
  localparam int D = 16;

  logic        clk = 0, rst_ni = 0;
  logic        fifo_en_i = 0, push_i = 0, brk_i = 0, rd_i = 0, status_clr_i = 0;
  logic [7:0]  push_data_i = 0;
  logic [3:0]  push_err_i = 0;
  logic        ready_o, empty_o, full_o, rx_irq_set_o, rx_irq_clr_o;
  logic [11:0] rd_data_o;
  logic [3:0]  status_o;

  always #2 clk = ~clk;

  uart_rx_fifo dut_i (
    .clk_i(clk), .rst_ni, .fifo_en_i, .push_i, .push_data_i, .push_err_i,
    .brk_i, .ready_o, .rd_i, .rd_data_o, .status_clr_i, .status_o,
    .empty_o, .full_o, .rx_irq_set_o, .rx_irq_clr_o
  );

  int n_tests = 0, n_fail = 0;
  // behavioural model
  int m_mem [D];
  int m_rp = 0, m_cnt = 0, m_mode = 0, m_status = 0;
  bit m_set = 0, m_clr = 0;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int act_depth(bit en);
    return en ? D : 1;
  endfunction

  // one cycle, starting and ending at a falling edge
  task automatic cyc(bit p, int d, int e, bit b, bit r, bit c, bit en);
    bit tog, rdy, kept, pop;
    push_i = p; push_data_i = 8'(d); push_err_i = 4'(e); brk_i = b;
    rd_i = r; status_clr_i = c; fifo_en_i = en;
    #1;
    tog = (en != m_mode);
    rdy = !tog && (m_cnt < act_depth(en));
    chk("R5 ready", int'(ready_o), int'(rdy));
    chk("R2 head entry", int'(rd_data_o), m_mem[m_rp]);
    @(posedge clk);
    if (r) m_status = m_mem[m_rp] >> 8;
    else if (c) m_status = 0;
    m_set = 0; m_clr = 0;
    if (tog) begin
      m_cnt = 0; m_rp = 0;
    end else begin
      kept = (p || b) && rdy;
      pop  = r && (m_cnt > 0);
      if (kept) m_mem[(m_rp + m_cnt) % D] = b ? 'h400 : ((e & 'hf) << 8) | (d & 'hff); // R11 slot
      if (pop)  m_rp = (m_rp + 1) % D;
      m_cnt = m_cnt + int'(kept) - int'(pop);
      m_set = kept && (m_cnt == 1);
      m_clr = r && (m_cnt == 0);
    end
    m_mode = en;
    @(negedge clk);
    chk("R4 empty", int'(empty_o), int'(m_cnt == 0));
    chk("R4 full", int'(full_o), int'(m_cnt == act_depth(en)));
    chk("R7 irq set", int'(rx_irq_set_o), int'(m_set));
    chk("R7 irq clr", int'(rx_irq_clr_o), int'(m_clr));
    chk("R9 status", int'(status_o), m_status);
  endtask

  task automatic idle(bit en);
    cyc(0, 0, 0, 0, 0, 0, en);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int snap;
    for (int i = 0; i < D; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 set", int'(rx_irq_set_o), 0);
    chk("R1 clr", int'(rx_irq_clr_o), 0);
    chk("R1 data", int'(rd_data_o), 0);
    rst_ni = 1;
    @(negedge clk);

    idle(1); // mode change into buffered mode (R6)
    chk("R6 empty after switch", int'(empty_o), 1);

    // R2 fill with distinct data and error patterns, R7 set on first
    for (int i = 0; i < D; i++) cyc(1, 'h30 + i, i % 16, 0, 0, 0, 1);
    chk("R4 full at depth", int'(full_o), 1);
    cyc(1, 'hEE, 0, 0, 0, 0, 1); // R5 refused
    chk("R5 refused push keeps head", int'(rd_data_o), 'h030);
    // drain
    for (int i = 0; i < D; i++) begin
      chk("R2 order", int'(rd_data_o & 'hff), 'h30 + i);
      cyc(0, 0, 0, 0, 1, 0, 1);
    end
    // R8 read while empty
    snap = rd_data_o;
    cyc(0, 0, 0, 0, 1, 0, 1);
    chk("R8 empty read head stable", int'(rd_data_o), snap);
    chk("R8 still empty", int'(empty_o), 1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    chk("R9 status cleared", int'(status_o), 0);

    // R3 break with simultaneous character
    cyc(1, 'h55, 'h3, 1, 0, 0, 1);
    chk("R3 break entry", int'(rd_data_o), 'h400);
    cyc(1, 'h41, 'h9, 0, 0, 0, 1);
    cyc(1, 'h42, 0, 0, 0, 0, 1);
    // R10 push and pop together
    cyc(1, 'h43, 'h1, 0, 1, 0, 1);
    chk("R10 head advanced", int'(rd_data_o), 'h941);
    chk("R9 break status", int'(status_o), 'h4);
    // R6 switch to holding mode with data present
    idle(0);
    chk("R6 empty after switch", int'(empty_o), 1);
    cyc(1, 'h61, 0, 0, 0, 0, 0);
    chk("R4 holding full", int'(full_o), 1);
    cyc(1, 'h62, 0, 0, 0, 0, 0); // R5 second refused
    chk("R5 holding keeps first", int'(rd_data_o & 'hff), 'h61);
    cyc(1, 'h63, 0, 0, 1, 0, 0);
    idle(1);

    // R11 wrap-around and mixed traffic
    for (int i = 0; i < 1500; i++) begin
      automatic int rv = $urandom;
      cyc(rv[0] | rv[1], rv[15:8], rv[19:16], rv[6:2] == 0, rv[3] & rv[4],
          rv[7:5] == 0, (rv[31:23] == 0) ? !m_mode[0] : m_mode[0]);
    end
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 0, 1);
    chk("R11 drained", int'(empty_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule